// File: doc/BRIEF.md
# Four-Phase Clock Sequencer with Stalls

This block steps a small microcoded processor through a repeating cycle of four timing phases. Phases one and two make up the fetch half of every instruction and phases three and four make up the execute half. Downstream control logic reads the current phase from three registered outputs: a one-hot strobe vector, a two-bit phase index and a flag that marks the execute half.

The cycle can be held only in particular phases, and each of those phases has its own hold condition. A reset request keeps the sequencer in phase one. The external wait request holds the sequence in phase two or in phase four, but phases one and three always move on. When the decoded instruction is the halt opcode while phase four is active, the sequencer freezes in phase four. From then on only a reset releases it, whatever the halt and wait inputs do.

Top module: `four_phase_seq`

## Requirements
- R1: At any clock edge where `rst` is high, the next phase is phase 1 (`phase_oh` = 4'b0001), and the halt freeze is cleared.
- R2: With no stall condition active, the phase order is 1, 2, 3, 4 and then 1 again, one step per clock edge.
- R3: At the first edge after `rst` falls, the sequencer moves from phase 1 to phase 2 unless reset is still active.
- R4: An edge taken in phase 2 with `wait_req` high leaves the sequencer in phase 2.
- R5: An edge taken in phase 4 with `wait_req` high leaves the sequencer in phase 4.
- R6: `wait_req` has no effect in phases 1 and 3. The edge always advances to phases 2 and 4 respectively.
- R7: An edge taken in phase 4 with `halt_op` high freezes the sequencer in phase 4. The freeze holds through later edges whatever the values of `halt_op` and `wait_req`, and only R1 ends it.
- R8: Outputs are registered. `phase_oh` bit k-1 is high only in phase k. `phase_idx` equals k-1 (0 to 3). `exec_half` is high in phases 3 and 4 and low in phases 1 and 2.
- R9: `halt_op` has no effect in phases 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset request; holds phase 1 |
| wait_req | input | 1 | External wait; holds phase 2 or phase 4 |
| halt_op | input | 1 | High when the current instruction is the halt opcode |
| phase_oh | output | 4 | One-hot phase strobes, bit 0 = phase 1 |
| phase_idx | output | 2 | Current phase number minus one |
| exec_half | output | 1 | High during the execute half (phases 3 and 4) |

## Verification
The phase register is observable at the ports one edge after every change, so a wrong transition shows up in the very next sample of `phase_oh` and `phase_idx`. A faulty halt flag shows up only after phase 4. If the flag fails to set, the sequencer leaves phase 4 on the first edge after `halt_op` drops. If the flag fails to clear, the sequencer sticks in phase 4 on the first pass after a reset. An error in the wait gating appears as a skipped or repeated phase in the same cycle that `wait_req` is sampled.

// File: rtl/four_phase_seq_pkg.sv
package four_phase_seq_pkg;

    localparam int unsigned PHASE_COUNT = 4;
    localparam int unsigned PHASE_W     = $clog2(PHASE_COUNT);

    typedef enum logic [PHASE_W-1:0] {
        PH_ONE   = 2'd0,
        PH_TWO   = 2'd1,
        PH_THREE = 2'd2,
        PH_FOUR  = 2'd3
    } phase_e;

    typedef struct packed {
        logic hold;
        logic frozen;
    } stall_t;

    typedef struct packed {
        logic [PHASE_COUNT-1:0] strobe;
        logic [PHASE_W-1:0]     index;
        logic                   exec;
    } phase_view_t;

    function automatic phase_e advance(input phase_e p);
        case (p)
            PH_ONE:   advance = PH_TWO;
            PH_TWO:   advance = PH_THREE;
            PH_THREE: advance = PH_FOUR;
            default:  advance = PH_ONE;
        endcase
    endfunction

    function automatic phase_view_t view_of(input phase_e p);
        phase_view_t v;
        v.strobe = '0;
        v.strobe[p] = 1'b1;
        v.index  = p;
        v.exec   = (p == PH_THREE) || (p == PH_FOUR);
        return v;
    endfunction

endpackage

// File: rtl/four_phase_stall_ctl.sv
module four_phase_stall_ctl
    import four_phase_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e cur,
    input  logic   wait_req,
    input  logic   halt_op,
    output stall_t stall
);
    logic frozen_q;
    logic freeze_now;

    assign freeze_now = (cur == PH_FOUR) && (halt_op || frozen_q);

    always_ff @(posedge clk) begin
        if (rst)
            frozen_q <= 1'b0;
        else if (cur == PH_FOUR && halt_op)
            frozen_q <= 1'b1;
    end

    always_comb begin
        stall.frozen = frozen_q;
        case (cur)
            PH_TWO:  stall.hold = wait_req;
            PH_FOUR: stall.hold = wait_req || freeze_now;
            default: stall.hold = 1'b0;
        endcase
    end
endmodule

// File: rtl/four_phase_state.sv
module four_phase_state
    import four_phase_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  stall_t stall,
    output phase_e cur,
    output phase_e nxt
);
    phase_e cur_q;

    always_comb begin
        if (rst)
            nxt = PH_ONE;
        else if (stall.hold)
            nxt = cur_q;
        else
            nxt = advance(cur_q);
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt;
    end

    assign cur = cur_q;
endmodule

// File: rtl/four_phase_out_reg.sv
module four_phase_out_reg
    import four_phase_seq_pkg::*;
(
    input  logic        clk,
    input  phase_e      nxt,
    output phase_view_t view
);
    always_ff @(posedge clk) begin
        view <= view_of(nxt);
    end
endmodule

// File: rtl/four_phase_seq.sv
module four_phase_seq
    import four_phase_seq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wait_req,
    input  logic                   halt_op,
    output logic [PHASE_COUNT-1:0] phase_oh,
    output logic [PHASE_W-1:0]     phase_idx,
    output logic                   exec_half
);
    phase_e      cur;
    phase_e      nxt;
    stall_t      stall;
    phase_view_t view;

    four_phase_stall_ctl u_stall (
        .clk      (clk),
        .rst      (rst),
        .cur      (cur),
        .wait_req (wait_req),
        .halt_op  (halt_op),
        .stall    (stall)
    );

    four_phase_state u_state (
        .clk   (clk),
        .rst   (rst),
        .stall (stall),
        .cur   (cur),
        .nxt   (nxt)
    );

    four_phase_out_reg u_out (
        .clk  (clk),
        .nxt  (nxt),
        .view (view)
    );

    assign phase_oh  = view.strobe;
    assign phase_idx = view.index;
    assign exec_half = view.exec;
endmodule

// File: rtl/four_phase_seq_chk.sv
module four_phase_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       wait_req,
    input logic       halt_op,
    input logic [3:0] phase_oh,
    input logic [1:0] phase_idx,
    input logic       exec_half
);
    logic started = 1'b0;
    logic rst_d   = 1'b0;

    always_ff @(posedge clk) begin
        started <= 1'b1;
        rst_d   <= rst;
    end

    always_ff @(posedge clk) begin
        if (started && rst_d)
            a_r1_reset_phase1: assert (phase_oh == 4'b0001);
    end

    a_r2_one_to_two: assert property (@(posedge clk) disable iff (rst)
        phase_oh[0] |=> phase_oh[1]);

    a_r4_wait_holds_two: assert property (@(posedge clk) disable iff (rst)
        (phase_oh[1] && wait_req) |=> phase_oh[1]);

    a_r5_wait_holds_four: assert property (@(posedge clk) disable iff (rst)
        (phase_oh[3] && wait_req) |=> phase_oh[3]);

    a_r6_three_advances: assert property (@(posedge clk) disable iff (rst)
        phase_oh[2] |=> phase_oh[3]);

    a_r7_halt_freezes: assert property (@(posedge clk) disable iff (rst)
        (phase_oh[3] && halt_op) |=> phase_oh[3]);

    a_r8_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_oh) == 1);

    a_r8_index_matches: assert property (@(posedge clk) disable iff (rst)
        phase_oh == (4'b0001 << phase_idx));

    a_r8_exec_half: assert property (@(posedge clk) disable iff (rst)
        exec_half == (phase_oh[2] || phase_oh[3]));
endmodule

bind four_phase_seq four_phase_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wait_req  (wait_req),
    .halt_op   (halt_op),
    .phase_oh  (phase_oh),
    .phase_idx (phase_idx),
    .exec_half (exec_half)
);

// File: tb/four_phase_seq_bench.sv
module four_phase_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wait_req = 1'b0;
    logic       halt_op = 1'b0;
    logic [3:0] phase_oh;
    logic [1:0] phase_idx;
    logic       exec_half;

    int checks = 0;
    int fails  = 0;
    int mph    = 1;
    bit mfrozen = 1'b0;
    bit prev_rst = 1'b1;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    four_phase_seq u_four_phase_seq (
        .clk       (clk),
        .rst       (rst),
        .wait_req  (wait_req),
        .halt_op   (halt_op),
        .phase_oh  (phase_oh),
        .phase_idx (phase_idx),
        .exec_half (exec_half)
    );

    function automatic logic [3:0] exp_strobe(int ph);
        return 4'b0001 << (ph - 1);
    endfunction

    function automatic string pick_tag(bit r, bit w, bit h, int ph, bit fz, bit pr);
        if (r) return "R1";
        if (fz || (ph == 4 && h)) return "R7";
        if (ph == 2 && w) return "R4";
        if (ph == 4 && w) return "R5";
        if ((ph == 1 || ph == 3) && w) return "R6";
        if (h) return "R9";
        if (pr) return "R3";
        return "R2";
    endfunction

    function automatic int model_next(bit r, bit w, bit h, int ph, bit fz);
        if (r) return 1;
        if (ph == 2 && w) return 2;
        if (ph == 4 && (w || h || fz)) return 4;
        return (ph % 4) + 1;
    endfunction

    task automatic check_outputs(string tag);
        checks++;
        if (phase_oh !== exp_strobe(mph)) begin
            fails++;
            $display("FAIL %s phase_oh actual=%b expected=%b", tag, phase_oh, exp_strobe(mph));
        end
        checks++;
        if (phase_idx !== 2'(mph - 1) || exec_half !== (mph >= 3)) begin
            fails++;
            $display("FAIL R8 idx/exec actual=%0d/%b expected=%0d/%b",
                     phase_idx, exec_half, mph - 1, (mph >= 3));
        end
    endtask

    task automatic step(bit r, bit w, bit h);
        string tag;
        @(negedge clk);
        rst = r; wait_req = w; halt_op = h;
        tag = pick_tag(r, w, h, mph, mfrozen, prev_rst);
        @(posedge clk);
        mph = model_next(r, w, h, mph, mfrozen);
        if (r) mfrozen = 1'b0;
        else if (tag == "R7") mfrozen = 1'b1;
        prev_rst = r;
        #1;
        check_outputs(tag);
    endtask

    task automatic go_to(int ph);
        for (int i = 0; i < 4 && mph != ph; i++) step(0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1: reset held for several edges keeps phase 1
        for (int i = 0; i < 3; i++) step(1, 0, 0);
        // R3 then R2: release and free-run
        for (int i = 0; i < 9; i++) step(0, 0, 0);
        // R6: wait ignored in phases 1 and 3
        go_to(1); step(0, 1, 0);
        go_to(3); step(0, 1, 0);
        // R4: wait holds phase 2
        go_to(2); for (int i = 0; i < 4; i++) step(0, 1, 0);
        step(0, 0, 0);
        // R5: wait holds phase 4
        go_to(4); for (int i = 0; i < 4; i++) step(0, 1, 0);
        step(0, 0, 0);
        // R9: halt_op outside phase 4 ignored
        for (int i = 0; i < 3; i++) step(0, 0, 1);
        // R7: halt in phase 4, then drop halt; frozen until reset
        go_to(4); step(0, 0, 1);
        for (int i = 0; i < 6; i++) step(0, i[0], 0);
        step(1, 0, 0);
        step(0, 0, 0);
        // R1: reset while in phase 3 returns to phase 1
        go_to(3); step(1, 1, 1);
        // mixed random run
        for (int i = 0; i < 3000; i++)
            step(($urandom % 50) == 0, ($urandom % 3) == 0, ($urandom % 40) == 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule